// File: doc/BRIEF.md
# SPI Master with Register Interface

This block is a programmable SPI master that a processor drives through a small 32-bit register window. Software pushes words into a four-entry transmit queue, picks a transfer length of 1 to 32 bits, and writes a start bit. The controller then shifts the low-order bits of one queued word out MSB first. At the same time it gathers the same number of bits from the slave into a four-entry receive queue. The receive word is right-justified, with the unused upper bits zero.

The serial clock is derived from the system clock by a programmable half-period divider. The bus runs in SPI mode 0: data changes while the clock is low and is sampled on its rising edge. One of four chip-select pins is chosen by a field. That pin can be held active by software for multi-word frames, or asserted automatically only for the duration of each transfer. A polarity bit picks the active level.

Status reports busy, done, queue levels and four sticky error conditions. Software clears the done and error flags by writing back ones.

Top module: `spim_ctrl`

Register offsets: control 0x000, select/enable 0x004, status 0x008, fill levels 0x01C, divider 0x020, transmit port 0x100, receive port 0x180.

## Requirements
- R1: After reset, status (0x008) reads 0x00A00000, meaning both queues are empty and nothing else is set. All four cs_n pins are high and sclk is low.
- R2: Writing control (0x000) with bit31 (enable), bit28 (master) and bit30 (start) set runs a transfer of len+1 bits, where len is taken from bits [4:0]. The transfer produces exactly len+1 rising edges of sclk. The bits on mosi are bits len..0 of the popped word, MSB first, and mosi never changes while sclk is high.
- R3: The bits sampled on miso at each rising edge of sclk are pushed into the receive queue as one word. The first bit ends up in bit len and the upper bits are zero. The word is read back through port 0x180.
- R4: Status bit31 (busy) is high while a transfer runs. Status bit30 (done) is set when the transfer ends, and writing 1 to bit30 clears it.
- R5: A start request is ignored while busy, so the running transfer keeps its length. A start request is also ignored when the same write has enable (bit31) or master (bit28) clear.
- R6: Select/enable bits [19:18] pick which cs_n pin is used. With control bit11 set, control bit12 drives the selected pin active. With bit11 clear, the selected pin is active only while busy. The active level is low, or high when control bit13 is 1. The other pins stay inactive.
- R7: A write to 0x100 when the transmit queue holds 4 words is dropped and sets status bit19. Fill levels (0x01C) report the transmit count in bits [5:0] and the receive count in bits [21:16]. Status bits 20 and 22 flag a full transmit and a full receive queue.
- R8: A read of 0x180 while the receive queue is empty returns 0 and sets status bit18.
- R9: A transfer that ends while the receive queue is full discards its word, sets status bit25 and leaves the count at 4.
- R10: A start with transmit enabled and an empty transmit queue shifts out zeros and sets status bit24.
- R11: Writing 0 to status leaves error bits 25, 24, 19 and 18 set. Writing 1 to a bit clears that bit.
- R12: Each half period of sclk lasts div+1 system clocks, where div is the divider register 0x020, bits [7:0].
- R13: With select/enable bit31 (receive enable) clear, no word is pushed into the receive queue. With bit30 (transmit enable) clear, the transmit queue is not popped and zeros are shifted out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive port) |
| bus_addr | input | 9 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle bus_rd is high |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Chip-select pins |

## Verification
Transfers of 1, 8, 13 and 32 bits run against a bench slave that records mosi and feeds miso from a known pattern. The 1-bit and 32-bit cases cover both ends of the length field. The 13-bit case exposes any error in right-justification or MSB ordering, because an odd length cannot be confused with a byte-aligned one.

A sequence of five queued words followed by five transfers covers several conditions together. The fourth word shifted out shows that the fifth write was dropped. The fifth transfer then meets an empty transmit queue and a full receive queue at the same time. Further cases start a transfer over a busy one, start with enable clear, switch chip-select modes and polarity, and change the divider; each shows whether a control bit really takes effect.

// File: rtl/spim_ctrl.sv
`timescale 1ns/1ps
module spim_ctrl #(
  parameter int DEPTH = 4,
  parameter int DIVW  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [8:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic [3:0]  cs_n
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [8:0] A_CMD = 9'h000, A_CMD2 = 9'h004, A_STAT = 9'h008,
                         A_LVL = 9'h01C, A_DIV = 9'h020, A_TX = 9'h100, A_RX = 9'h180;

  logic en_q, mst_q, cspol_q, csval_q, cssoft_q;
  logic [4:0] len_q;
  logic rxen_q, txen_q;
  logic [1:0] sel_q;
  logic [DIVW-1:0] div_q, dcnt;
  logic busy_q, rdy_q, rx_ovf_q, tx_unr_q, tx_ovf_q, rx_unr_q, sclk_q;
  logic [31:0] tx_mem [DEPTH];
  logic [31:0] rx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [31:0] tsh, rsh, rd_mux, tx_word;
  logic [5:0] bit_cnt, nbits;

  wire wr_cmd  = bus_wr && bus_addr == A_CMD;
  wire wr_cmd2 = bus_wr && bus_addr == A_CMD2;
  wire wr_stat = bus_wr && bus_addr == A_STAT;
  wire wr_div  = bus_wr && bus_addr == A_DIV;
  wire wr_tx   = bus_wr && bus_addr == A_TX;
  wire rd_rx   = bus_rd && bus_addr == A_RX;

  wire tx_full  = tx_cnt == CW'(DEPTH);
  wire tx_empty = tx_cnt == '0;
  wire rx_full  = rx_cnt == CW'(DEPTH);
  wire rx_empty = rx_cnt == '0;

  wire go        = wr_cmd && bus_wdata[30] && bus_wdata[31] && bus_wdata[28] && !busy_q;
  wire tick      = busy_q && dcnt == div_q;
  wire rise      = tick && !sclk_q;
  wire fall      = tick && sclk_q;
  wire last_fall = fall && bit_cnt == nbits;
  wire tx_push   = wr_tx && !tx_full;
  wire tx_pop    = go && txen_q && !tx_empty;
  wire rx_push   = last_fall && rxen_q && !rx_full;
  wire rx_pop    = rd_rx && !rx_empty;

  logic unused_ok;
  assign unused_ok = &{1'b0, bus_wdata[29], bus_wdata[27:26], bus_wdata[23:20], bus_wdata[17:14]};

  assign tx_word = tx_pop ? tx_mem[tx_rp] : 32'h0;
  assign sclk = sclk_q;
  assign mosi = tsh[31];

  wire cs_on = cssoft_q ? csval_q : busy_q;
  for (genvar i = 0; i < 4; i++) begin : g_cs
    assign cs_n[i] = (cs_on && sel_q == 2'(i)) ? cspol_q : ~cspol_q;
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_CMD: begin
        rd_mux[31] = en_q;  rd_mux[28] = mst_q;  rd_mux[13] = cspol_q;
        rd_mux[12] = csval_q; rd_mux[11] = cssoft_q; rd_mux[4:0] = len_q;
      end
      A_CMD2: begin
        rd_mux[31] = rxen_q; rd_mux[30] = txen_q; rd_mux[19:18] = sel_q;
      end
      A_STAT: begin
        rd_mux[31] = busy_q;   rd_mux[30] = rdy_q;
        rd_mux[25] = rx_ovf_q; rd_mux[24] = tx_unr_q;
        rd_mux[23] = rx_empty; rd_mux[22] = rx_full;
        rd_mux[21] = tx_empty; rd_mux[20] = tx_full;
        rd_mux[19] = tx_ovf_q; rd_mux[18] = rx_unr_q;
      end
      A_LVL: begin
        rd_mux[21:16] = 6'(rx_cnt); rd_mux[5:0] = 6'(tx_cnt);
      end
      A_DIV: rd_mux[DIVW-1:0] = div_q;
      A_RX:  rd_mux = rx_empty ? 32'h0 : rx_mem[rx_rp];
      default: rd_mux = '0;
    endcase
  end
  assign bus_rdata = bus_rd ? rd_mux : 32'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {en_q, mst_q, cspol_q, csval_q, cssoft_q} <= '0;
      len_q <= '0;
      {rxen_q, txen_q} <= '0;
      sel_q <= '0;
      div_q <= '0;
    end else begin
      if (wr_cmd) begin
        en_q <= bus_wdata[31];    mst_q <= bus_wdata[28];
        cspol_q <= bus_wdata[13]; csval_q <= bus_wdata[12];
        cssoft_q <= bus_wdata[11]; len_q <= bus_wdata[4:0];
      end
      if (wr_cmd2) begin
        rxen_q <= bus_wdata[31]; txen_q <= bus_wdata[30]; sel_q <= bus_wdata[19:18];
      end
      if (wr_div) div_q <= bus_wdata[DIVW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; sclk_q <= 1'b0; dcnt <= '0;
      bit_cnt <= '0; nbits <= '0; tsh <= '0; rsh <= '0;
    end else if (go) begin
      busy_q  <= 1'b1;
      sclk_q  <= 1'b0;
      dcnt    <= '0;
      bit_cnt <= '0;
      nbits   <= {1'b0, bus_wdata[4:0]} + 6'd1;
      tsh     <= tx_word << (5'd31 - bus_wdata[4:0]);
      rsh     <= '0;
    end else if (busy_q) begin
      dcnt <= tick ? '0 : dcnt + 1'b1;
      if (rise) begin
        sclk_q  <= 1'b1;
        rsh     <= {rsh[30:0], miso};
        bit_cnt <= bit_cnt + 6'd1;
      end
      if (fall) begin
        sclk_q <= 1'b0;
        tsh    <= tsh << 1;
        if (last_fall) busy_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {rdy_q, rx_ovf_q, tx_unr_q, tx_ovf_q, rx_unr_q} <= '0;
    end else begin
      if (wr_stat) begin
        if (bus_wdata[30]) rdy_q    <= 1'b0;
        if (bus_wdata[25]) rx_ovf_q <= 1'b0;
        if (bus_wdata[24]) tx_unr_q <= 1'b0;
        if (bus_wdata[19]) tx_ovf_q <= 1'b0;
        if (bus_wdata[18]) rx_unr_q <= 1'b0;
      end
      if (last_fall) rdy_q <= 1'b1;
      if (last_fall && rxen_q && rx_full) rx_ovf_q <= 1'b1;
      if (go && txen_q && tx_empty) tx_unr_q <= 1'b1;
      if (wr_tx && tx_full) tx_ovf_q <= 1'b1;
      if (rd_rx && rx_empty) rx_unr_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= (tx_wp == PW'(DEPTH - 1)) ? '0 : tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= (tx_rp == PW'(DEPTH - 1)) ? '0 : tx_rp + 1'b1;
      if (rx_push) rx_wp <= (rx_wp == PW'(DEPTH - 1)) ? '0 : rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= (rx_rp == PW'(DEPTH - 1)) ? '0 : rx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= bus_wdata;
    if (rx_push) rx_mem[rx_wp] <= rsh;
  end
endmodule

// File: rtl/spim_ctrl_chk.sv
`timescale 1ns/1ps
module spim_ctrl_chk #(
  parameter int DEPTH = 4,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [8:0]    bus_addr,
  input logic [31:0]   bus_wdata,
  input logic [31:0]   bus_rdata,
  input logic          sclk,
  input logic          mosi,
  input logic [3:0]    cs_n,
  input logic          cspol,
  input logic          busy,
  input logic          rdy,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic          tx_ovf,
  input logic          rx_unr
);
  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !sclk); // R2
  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (sclk && $past(sclk)) |-> $stable(mosi)); // R2
  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> rdy); // R4
  AST_START_ONLY_ON_GO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_wr && bus_addr == 9'h000 && bus_wdata[30] && bus_wdata[31] && bus_wdata[28])); // R5
  AST_CS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cs_n ^ {4{~cspol}})); // R6
  AST_TX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 9'h100 && tx_cnt == CW'(DEPTH)) |=> (tx_ovf && tx_cnt == CW'(DEPTH))); // R7
  AST_RX_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 9'h180 && rx_cnt == '0) |-> bus_rdata == 32'h0); // R8
  AST_RX_UNR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 9'h180 && rx_cnt == '0) |=> rx_unr); // R8
endmodule

bind spim_ctrl spim_ctrl_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
  .cspol(cspol_q), .busy(busy_q), .rdy(rdy_q), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
  .tx_ovf(tx_ovf_q), .rx_unr(rx_unr_q)
);

// File: tb/spim_ctrl_bench.sv
`timescale 1ns/1ps
module spim_ctrl_bench;
  localparam logic [8:0] A_CMD = 9'h000, A_CMD2 = 9'h004, A_STAT = 9'h008,
                         A_LVL = 9'h01C, A_DIV = 9'h020, A_TX = 9'h100, A_RX = 9'h180;
  localparam logic [31:0] EN = 32'h8000_0000, GO = 32'h4000_0000, MS = 32'h1000_0000;
  localparam logic [31:0] RXEN = 32'h8000_0000, TXEN = 32'h4000_0000;

  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0, miso;
  logic [8:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic sclk, mosi;
  logic [3:0] cs_n;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int s_rises = 0, s_base = 0, s_n = 0;
  logic [31:0] s_pat = '0, s_in = '0;
  time t_last = 0, t_prev = 0;

  always #10 clk = ~clk;

  spim_ctrl u_spim_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n)
  );

  always @* begin
    int k;
    k = s_rises - s_base;
    miso = (k < s_n && k >= 0) ? s_pat[s_n - 1 - k] : 1'b0;
  end

  always @(posedge sclk) begin
    s_in <= {s_in[30:0], mosi};
    s_rises <= s_rises + 1;
    t_prev <= t_last;
    t_last <= $time;
  end

  function automatic logic [31:0] mask(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] st;
    for (int i = 0; i < 5000; i++) begin
      rd(A_STAT, st);
      if (!st[31]) return;
    end
    chk("R4 busy never cleared", 32'h1, 32'h0);
  endtask

  task automatic start(input int n, input logic [31:0] pat, input logic [31:0] extra);
    s_pat = pat; s_n = n; s_base = s_rises;
    wr(A_CMD, EN | MS | GO | extra | 32'(n - 1));
  endtask

  task automatic xfer(input int n, input logic [31:0] pat, input logic [31:0] extra);
    start(n, pat, extra);
    wait_idle();
  endtask

  task automatic t_reset();
    logic [31:0] st;
    rd(A_STAT, st);
    chk("R1 status after reset", st, 32'h00A0_0000);
    chk("R1 cs_n after reset", {28'h0, cs_n}, 32'hF);
    chk("R1 sclk after reset", {31'h0, sclk}, 32'h0);
  endtask

  task automatic t_basic(input int n, input logic [31:0] tx, input logic [31:0] pat);
    logic [31:0] d;
    wr(A_TX, tx);
    xfer(n, pat, 32'h0);
    chk("R2 sclk rising edges", 32'(s_rises - s_base), 32'(n));
    chk("R2 mosi bits MSB first", s_in & mask(n), tx & mask(n));
    rd(A_STAT, d);
    chk("R4 done flag set", {31'h0, d[30]}, 32'h1);
    rd(A_RX, d);
    chk("R3 received word", d, pat & mask(n));
    wr(A_STAT, 32'h4000_0000);
    rd(A_STAT, d);
    chk("R4 done cleared by write-one", {31'h0, d[30]}, 32'h0);
  endtask

  task automatic t_busy_go();
    logic [31:0] d;
    int b;
    wr(A_TX, 32'hCAFE_F00D);
    start(32, 32'h0F0F_0F0F, 32'h0);
    repeat (4) @(negedge clk);
    rd(A_STAT, d);
    chk("R4 busy during transfer", {31'h0, d[31]}, 32'h1);
    wr(A_CMD, EN | MS | GO | 32'd7);
    wait_idle();
    chk("R5 start while busy ignored", 32'(s_rises - s_base), 32'd32);
    rd(A_RX, d);
    chk("R3 32-bit receive after ignored start", d, 32'h0F0F_0F0F);
    b = s_rises;
    wr(A_CMD, MS | GO | 32'd7);
    repeat (10) @(negedge clk);
    rd(A_STAT, d);
    chk("R5 start without enable ignored", {31'h0, d[31]}, 32'h0);
    wr(A_CMD, EN | GO | 32'd7);
    repeat (10) @(negedge clk);
    chk("R5 start without master ignored", 32'(s_rises - b), 32'h0);
    wr(A_STAT, 32'h4000_0000);
  endtask

  task automatic t_cs();
    wr(A_CMD2, RXEN | TXEN | (32'd2 << 18));
    wr(A_CMD, 32'h0000_1800);
    chk("R6 soft select active low pin 2", {28'h0, cs_n}, 32'hB);
    wr(A_CMD, 32'h0000_3800);
    chk("R6 soft select active high polarity", {28'h0, cs_n}, 32'h4);
    wr(A_CMD, 32'h0000_0800);
    chk("R6 soft select released", {28'h0, cs_n}, 32'hF);
    wr(A_CMD2, RXEN | TXEN | (32'd1 << 18));
    wr(A_TX, 32'h5A);
    start(8, 32'h0, 32'h0);
    repeat (3) @(negedge clk);
    chk("R6 hardware select during busy", {28'h0, cs_n}, 32'hD);
    wait_idle();
    chk("R6 hardware select after transfer", {28'h0, cs_n}, 32'hF);
    begin logic [31:0] d; rd(A_RX, d); end
    wr(A_STAT, 32'h4000_0000);
  endtask

  task automatic t_queues();
    logic [31:0] d;
    for (int i = 1; i <= 5; i++) wr(A_TX, 32'(i * 8'h11));
    rd(A_LVL, d);
    chk("R7 transmit fill level", d, 32'h0000_0004);
    rd(A_STAT, d);
    chk("R7 overflow and full flags", {30'h0, d[20], d[19]}, 32'h3);
    for (int i = 1; i <= 4; i++) begin
      xfer(8, 32'(8'hA0 + i), 32'h0);
      chk("R7 queued word order", s_in & 32'hFF, 32'(i * 8'h11));
    end
    rd(A_STAT, d);
    chk("R7 receive full flag", {31'h0, d[22]}, 32'h1);
    xfer(8, 32'hEE, 32'h0);
    chk("R10 empty queue shifts zeros", s_in & 32'hFF, 32'h0);
    rd(A_STAT, d);
    chk("R10 underrun flag", {31'h0, d[24]}, 32'h1);
    chk("R9 receive overflow flag", {31'h0, d[25]}, 32'h1);
    rd(A_LVL, d);
    chk("R9 receive level held at 4", d, 32'h0004_0000);
    for (int i = 1; i <= 4; i++) begin
      rd(A_RX, d);
      chk("R9 stored words kept", d, 32'(8'hA0 + i));
    end
    rd(A_RX, d);
    chk("R8 empty read returns zero", d, 32'h0);
    rd(A_STAT, d);
    chk("R8 receive underrun flag", {31'h0, d[18]}, 32'h1);
    wr(A_STAT, 32'h0);
    rd(A_STAT, d);
    chk("R11 zero write keeps error flags", d & 32'h030C_0000, 32'h030C_0000);
    wr(A_STAT, 32'h430C_0000);
    rd(A_STAT, d);
    chk("R11 write-one clears flags", d & 32'h430C_0000, 32'h0);
  endtask

  task automatic t_enables();
    logic [31:0] d;
    wr(A_CMD2, TXEN);
    wr(A_TX, 32'h99);
    xfer(8, 32'h42, 32'h0);
    rd(A_LVL, d);
    chk("R13 receive disabled stores nothing", d, 32'h0);
    wr(A_CMD2, RXEN);
    wr(A_TX, 32'h77);
    xfer(8, 32'h24, 32'h0);
    chk("R13 transmit disabled shifts zeros", s_in & 32'hFF, 32'h0);
    rd(A_LVL, d);
    chk("R13 transmit queue not popped", d, 32'h0001_0001);
    rd(A_RX, d);
    chk("R13 receive still works", d, 32'h24);
    wr(A_CMD2, RXEN | TXEN);
    wr(A_STAT, 32'h4000_0000);
  endtask

  task automatic t_div();
    logic [31:0] d;
    wr(A_DIV, 32'd3);
    xfer(4, 32'h9, 32'h0);
    chk("R12 sclk period for divider 3", 32'(t_last - t_prev), 32'd160);
    rd(A_RX, d);
    chk("R3 4-bit receive", d, 32'h9);
    wr(A_DIV, 32'd1);
  endtask

  initial begin
    #8_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    wr(A_DIV, 32'd1);
    wr(A_CMD2, RXEN | TXEN);
    t_basic(8, 32'hA5, 32'h3C);
    t_basic(32, 32'hDEAD_BEEF, 32'h1234_5678);
    t_basic(1, 32'h1, 32'h1);
    t_basic(13, 32'h1B6D, 32'h0ACE);
    t_busy_go();
    t_cs();
    t_queues();
    t_enables();
    t_div();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule